// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block connects an internal request port to an external asynchronous device bus. An internal requester offers a transfer with a valid/ready handshake: a 32-bit byte address, write data and a read/write flag. The block decodes the top address nibble into one of four 256 MB chip-enable spaces. It then runs the external pins through three phases: setup, strobe and hold. It finishes with a one-cycle response that carries the read data, or zero after a write.

Each space has its own 32-bit control word in a small register file. The word gives the device type and separate setup, strobe and hold lengths for reads and for writes, all in clock cycles. Two different devices can therefore share the bus with different timing, for example a converter that needs long strobes and a fast SRAM. The block sequences only spaces typed as 32-bit asynchronous. A transfer to any other space, or to an address outside the four windows, is answered at once and never touches the pins.

Top module: `async_mem_ctrl`

## Requirements
- R1: An accepted request whose address has top nibble 0x8, 0x9, 0xA or 0xB selects space 0, 1, 2 or 3. Only that space's active-low enable `ext_ce_n[addr[29:28]]` is low, for every cycle from setup to hold. Outside a transfer all enables are high.
- R2: The control words are stored at byte offsets 0x08 (space 0), 0x04 (space 1), 0x10 (space 2) and 0x14 (space 3). A general word is stored at 0x00. Each reads back on `cfg_rdata` when its offset is on `cfg_addr`. Any other offset reads zero, and a write to it changes no stored word. All words reset to zero.
- R3: A read drives the enable for S setup cycles with `ext_oe_n` high. It then holds `ext_oe_n` low for T strobe cycles. It then holds the enable for H cycles with `ext_oe_n` high. `ext_we_n` stays high and `ext_dout_en` stays low throughout.
- R4: A write drives `ext_dout_en` high, with `ext_dout` equal to the request data and `ext_addr` equal to `req_addr[27:2]`, for every cycle of setup, strobe and hold. `ext_we_n` is low only for the T strobe cycles. `ext_oe_n` stays high.
- R5: The read response data equals the value on `ext_din` at the clock edge that ends the last strobe cycle.
- R6: A setup, strobe or hold field equal to zero gives a phase of one cycle.
- R7: A request outside the four spaces gets `rsp_valid` in the cycle after acceptance, with zero data. No enable, strobe or data-drive pin moves.
- R8: A request to a space whose type field is not 0010b is handled as in R7.
- R9: `req_ready` is high after reset. It is low from the cycle after acceptance until the transfer ends. It is high again in the cycle where `rsp_valid` is high. `rsp_valid` pulses for one cycle, one cycle after the last hold cycle.
- R10: Control-word fields: write setup [31:28], write strobe [27:22], write hold [21:20], read setup [19:16], read strobe [13:8], type [7:4], read hold [2:0]. Bits [15:14] and [3] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at `cfg_addr` |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Transfer complete, one cycle |
| rsp_rdata | output | DATA_W | Read data, zero for writes and misses |
| ext_ce_n | output | 4 | Active-low space enables |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write enable |
| ext_addr | output | ADDR_W-6 | External word address |
| ext_dout | output | DATA_W | Data driven to the device |
| ext_dout_en | output | 1 | Drive enable for `ext_dout` |
| ext_din | input | DATA_W | Data from the device |

## Verification
On every cycle, the assertions check the bus rules that hold whatever the timing. At most one enable is low, and none is low while the port is ready. Output enable and write enable are never low together. The data drive is on during every write strobe and off during every read strobe. Driven address and data do not change within a transfer. A response comes only when the block is idle.

Only the bench scenarios can show the timing itself. The bench measures the exact setup, strobe and hold lengths against randomly packed control words, including zero and maximum fields. It checks which edge captures read data by changing `ext_din` on every strobe cycle. It also checks that misses and non-asynchronous spaces return zero, and that the register offsets map to the right space.

// File: rtl/amc_pkg.sv
package amc_pkg;

    localparam int NUM_SPACES = 4;
    localparam int SP_W       = $clog2(NUM_SPACES);
    localparam int SETUP_W    = 4;
    localparam int STROBE_W   = 6;
    localparam int HOLD_W     = 3;
    localparam int TYPE_W     = 4;
    localparam int CNT_W      = STROBE_W;
    localparam int CFG_W      = 32;

    localparam logic [TYPE_W-1:0] TYPE_ASYNC32 = 4'b0010;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
    } timing_t;

    typedef struct packed {
        timing_t             wr;
        timing_t             rd;
        logic [TYPE_W-1:0]   mtype;
    } space_cfg_t;

    // Split a packed control word into its timing fields.
    function automatic space_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        space_cfg_t c;
        c.wr.setup  = w[31:28];
        c.wr.strobe = w[27:22];
        c.wr.hold   = {1'b0, w[21:20]};
        c.rd.setup  = w[19:16];
        c.rd.strobe = w[13:8];
        c.mtype     = w[7:4];
        c.rd.hold   = w[2:0];
        return c;
    endfunction

    // Counter start value for a phase; a zero field still lasts one cycle.
    function automatic logic [CNT_W-1:0] load_count(input logic [CNT_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    // Register byte offset of each space's control word.
    function automatic logic [7:0] space_offset(input int idx);
        case (idx)
            0:       return 8'h08;
            1:       return 8'h04;
            2:       return 8'h10;
            default: return 8'h14;
        endcase
    endfunction

endpackage

// File: rtl/amc_regfile.sv
module amc_regfile
    import amc_pkg::*;
#(
    parameter int CFG_AW = 5,
    parameter logic [CFG_W-1:0] RESET_WORD = '0
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [CFG_AW-1:0]               addr,
    input  logic [CFG_W-1:0]                wdata,
    output logic [CFG_W-1:0]                rdata,
    output logic [NUM_SPACES-1:0][CFG_W-1:0] space_words
);

    localparam logic [CFG_AW-1:0] GLOBAL_OFS = '0;

    logic [CFG_W-1:0] global_word;

    always_ff @(posedge clk) begin
        if (rst)
            global_word <= RESET_WORD;
        else if (wr_en && addr == GLOBAL_OFS)
            global_word <= wdata;
    end

    for (genvar i = 0; i < NUM_SPACES; i++) begin : g_space
        localparam logic [CFG_AW-1:0] OFS = CFG_AW'(space_offset(i));
        always_ff @(posedge clk) begin
            if (rst)
                space_words[i] <= RESET_WORD;
            else if (wr_en && addr == OFS)
                space_words[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == GLOBAL_OFS)
            rdata = global_word;
        for (int i = 0; i < NUM_SPACES; i++) begin
            if (addr == CFG_AW'(space_offset(i)))
                rdata = space_words[i];
        end
    end

endmodule

// File: rtl/amc_decode.sv
module amc_decode
    import amc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [3:0] BASE_NIB = 4'h8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SP_W-1:0]   idx
);

    logic [3:0] rel;

    // Values below the base wrap around to a large number and miss.
    assign rel = addr[ADDR_W-1 -: 4] - BASE_NIB;
    assign hit = (rel < 4'(NUM_SPACES));
    assign idx = rel[SP_W-1:0];

endmodule

// File: rtl/amc_seq.sv
module amc_seq
    import amc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EAW    = 26
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  go,
    input  logic                  we,
    input  logic [SP_W-1:0]       space,
    input  timing_t               tim,
    input  logic [EAW-1:0]        waddr,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  idle,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [NUM_SPACES-1:0] ce_n,
    output logic                  oe_n,
    output logic                  we_n,
    output logic [EAW-1:0]        ext_addr,
    output logic [DATA_W-1:0]     ext_dout,
    output logic                  dout_en,
    input  logic [DATA_W-1:0]     ext_din
);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    timing_t          tim_q;
    logic             we_q;
    logic [SP_W-1:0]  space_q;
    logic             last;
    logic             active;

    assign last   = (cnt == '0);
    assign active = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            tim_q     <= '0;
            we_q      <= 1'b0;
            space_q   <= '0;
            ext_addr  <= '0;
            ext_dout  <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        rsp_rdata <= '0;
                        if (go) begin
                            phase    <= PH_SETUP;
                            cnt      <= load_count(CNT_W'(tim.setup));
                            tim_q    <= tim;
                            we_q     <= we;
                            space_q  <= space;
                            ext_addr <= waddr;
                            ext_dout <= wdata;
                        end else begin
                            rsp_valid <= 1'b1;
                        end
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_STROBE;
                        cnt   <= load_count(tim_q.strobe);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        phase <= PH_HOLD;
                        cnt   <= load_count(CNT_W'(tim_q.hold));
                        if (!we_q)
                            rsp_rdata <= ext_din;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (last) begin
                        phase     <= PH_IDLE;
                        rsp_valid <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    for (genvar i = 0; i < NUM_SPACES; i++) begin : g_ce
        assign ce_n[i] = !(active && space_q == SP_W'(i));
    end

    assign idle    = !active;
    assign oe_n    = !(phase == PH_STROBE && !we_q);
    assign we_n    = !(phase == PH_STROBE && we_q);
    assign dout_en = active && we_q;

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
    import amc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CFG_AW = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output logic [CFG_W-1:0]      cfg_rdata,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [NUM_SPACES-1:0] ext_ce_n,
    output logic                  ext_oe_n,
    output logic                  ext_we_n,
    output logic [ADDR_W-7:0]     ext_addr,
    output logic [DATA_W-1:0]     ext_dout,
    output logic                  ext_dout_en,
    input  logic [DATA_W-1:0]     ext_din
);

    localparam int EAW = ADDR_W - 6;

    logic [NUM_SPACES-1:0][CFG_W-1:0] space_words;
    logic                             hit;
    logic [SP_W-1:0]                  idx;
    space_cfg_t                       cfg_sel;
    timing_t                          tim_sel;
    logic                             start;
    logic                             go;
    logic                             unused_bits;

    amc_regfile #(.CFG_AW(CFG_AW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .rdata       (cfg_rdata),
        .space_words (space_words)
    );

    amc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .hit  (hit),
        .idx  (idx)
    );

    assign cfg_sel = unpack_cfg(space_words[idx]);
    assign tim_sel = req_we ? cfg_sel.wr : cfg_sel.rd;
    assign start   = req_valid && req_ready;
    assign go      = hit && (cfg_sel.mtype == TYPE_ASYNC32);

    assign unused_bits = ^{req_addr[1:0], space_words[idx][15:14], space_words[idx][3]};

    amc_seq #(.DATA_W(DATA_W), .EAW(EAW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .go        (go),
        .we        (req_we),
        .space     (idx),
        .tim       (tim_sel),
        .waddr     (req_addr[EAW+1:2]),
        .wdata     (req_wdata),
        .idle      (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .ce_n      (ext_ce_n),
        .oe_n      (ext_oe_n),
        .we_n      (ext_we_n),
        .ext_addr  (ext_addr),
        .ext_dout  (ext_dout),
        .dout_en   (ext_dout_en),
        .ext_din   (ext_din)
    );

endmodule

// File: rtl/amc_chk.sv
module amc_chk
    import amc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EAW    = 26
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_ready,
    input logic                  rsp_valid,
    input logic [NUM_SPACES-1:0] ext_ce_n,
    input logic                  ext_oe_n,
    input logic                  ext_we_n,
    input logic                  ext_dout_en,
    input logic [DATA_W-1:0]     ext_dout,
    input logic [EAW-1:0]        ext_addr
);

    // R1
    ce_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ext_ce_n));

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&ext_ce_n));

    // R3
    oe_with_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_oe_n |-> ($countones(~ext_ce_n) == 1) && !ext_dout_en);

    // R4
    we_drives_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_we_n |-> ext_dout_en && ($countones(~ext_ce_n) == 1));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!ext_oe_n && !ext_we_n));

    // R4
    drive_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_dout_en && $past(ext_dout_en)) |-> ($stable(ext_dout) && $stable(ext_addr)));

    // R9
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready && (&ext_ce_n));

endmodule

bind async_mem_ctrl amc_chk #(.DATA_W(DATA_W), .EAW(ADDR_W - 6)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .ext_ce_n    (ext_ce_n),
    .ext_oe_n    (ext_oe_n),
    .ext_we_n    (ext_we_n),
    .ext_dout_en (ext_dout_en),
    .ext_dout    (ext_dout),
    .ext_addr    (ext_addr)
);

// File: tb/tb_async_mem_ctrl.sv
`timescale 1ns/1ps
module tb_async_mem_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  ext_ce_n;
    logic        ext_oe_n, ext_we_n, ext_dout_en;
    logic [25:0] ext_addr;
    logic [31:0] ext_dout;
    logic [31:0] ext_din;
    logic [31:0] dev_val = '0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign ext_din = ext_oe_n ? 32'hDEAD_BEEF : dev_val;

    async_mem_ctrl dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_dout_en(ext_dout_en),
        .ext_din(ext_din)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Control-word packing per R10
    function automatic logic [31:0] pack(input int ws, input int wst, input int wh,
                                         input int rs, input int rst_f, input int rh, input int mt);
        logic [31:0] w;
        w = '0;
        w[31:28] = 4'(ws);  w[27:22] = 6'(wst); w[21:20] = 2'(wh);
        w[19:16] = 4'(rs);  w[13:8]  = 6'(rst_f); w[7:4] = 4'(mt);
        w[2:0]   = 3'(rh);
        return w;
    endfunction

    function automatic int plen(input int f);
        return (f == 0) ? 1 : f;
    endfunction

    function automatic logic [4:0] sp_ofs(input int sp);
        case (sp)
            0: return 5'h08;
            1: return 5'h04;
            2: return 5'h10;
            default: return 5'h14;
        endcase
    endfunction

    task automatic cfg_write(input logic [4:0] ofs, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [4:0] ofs, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = ofs;
        #1 v = cfg_rdata;
    endtask

    task automatic xfer(input logic [31:0] addr, input bit we, input logic [31:0] wd,
                        input logic [31:0] base, input logic [3:0] ce_exp,
                        output int s, output int t, output int h, output logic [31:0] rd,
                        output int bad_ce, output int bad_drv, output int bad_rdy);
        int guard;
        s = 0; t = 0; h = 0; rd = '0; bad_ce = 0; bad_drv = 0; bad_rdy = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_we = we; req_wdata = wd;
        guard = 0;
        while (!req_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 1000) begin
            if (ext_ce_n != ce_exp) bad_ce++;
            if (req_ready) bad_rdy++;
            if (ext_addr != addr[27:2]) bad_drv++;
            if (we) begin
                if (!ext_oe_n) bad_drv++;
                if (!ext_dout_en || ext_dout != wd) bad_drv++;
                if (!ext_we_n) t++;
                else if (t == 0) s++;
                else h++;
            end else begin
                if (!ext_we_n || ext_dout_en) bad_drv++;
                if (!ext_oe_n) begin
                    dev_val = base + 32'(t);
                    t++;
                end else if (t == 0) s++;
                else h++;
            end
            @(negedge clk);
            guard++;
        end
        if (!rsp_valid) bad_rdy++;
        rd = rsp_rdata;
        if (ext_ce_n != 4'hF || !ext_oe_n || !ext_we_n || ext_dout_en || !req_ready) bad_rdy++;
        @(negedge clk);
        if (rsp_valid) bad_rdy++;
    endtask

    // Transfer to a sequenced space, checked against expected lengths.
    task automatic run_hit(input int sp, input logic [31:0] off, input bit we,
                           input logic [31:0] wd, input int es, input int et, input int eh,
                           input string tag);
        int s, t, h, bc, bd, br;
        logic [31:0] rd, base, addr;
        base = $urandom;
        addr = 32'h8000_0000 + (32'(sp) << 28) + (off & 32'h0FFF_FFFC);
        xfer(addr, we, wd, base, ~(4'b0001 << sp), s, t, h, rd, bc, bd, br);
        chk(s == es, {tag, " setup length"}, 32'(s), 32'(es));
        chk(t == et, {tag, " strobe length"}, 32'(t), 32'(et));
        chk(h == eh, {tag, " hold length"}, 32'(h), 32'(eh));
        chk(bc == 0, "R1 enable pattern", 32'(bc), 0);
        chk(bd == 0, we ? "R4 write drive" : "R3 read pins", 32'(bd), 0);
        chk(br == 0, "R9 ready/response", 32'(br), 0);
        if (we) chk(rd == 0, "R4 write response data", rd, 0);
        else    chk(rd == base + 32'(et - 1), "R5 read capture", rd, base + 32'(et - 1));
    endtask

    // Transfer expected to finish at once with no pin activity.
    task automatic run_miss(input logic [31:0] addr, input bit we, input string tag);
        int s, t, h, bc, bd, br;
        logic [31:0] rd;
        xfer(addr, we, 32'h1234_5678, 32'h5555_0000, 4'hF, s, t, h, rd, bc, bd, br);
        chk(s + t + h == 0, {tag, " no phases"}, 32'(s + t + h), 0);
        chk(bc == 0 && bd == 0 && br == 0, {tag, " quiet pins"}, 32'(bc + bd + br), 0);
        chk(rd == 0, {tag, " zero data"}, rd, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] words [5];
        logic [4:0]  ofs [5];
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk(req_ready && !rsp_valid, "R9 reset ready", {30'b0, req_ready, rsp_valid}, 32'h2);
        chk(ext_ce_n == 4'hF && ext_oe_n && ext_we_n && !ext_dout_en, "R1 reset pins",
            {25'b0, ext_ce_n, ext_oe_n, ext_we_n, ext_dout_en}, {25'b0, 4'hF, 3'b110});
        cfg_read(5'h14, v);
        chk(v == 0, "R2 reset word", v, 0);

        // R2 register file map
        ofs[0] = 5'h00; ofs[1] = 5'h04; ofs[2] = 5'h08; ofs[3] = 5'h10; ofs[4] = 5'h14;
        for (int i = 0; i < 5; i++) begin
            words[i] = 32'hA500_0000 | 32'(i * 32'h0101);
            cfg_write(ofs[i], words[i]);
        end
        cfg_write(5'h0C, 32'hFFFF_FFFF);
        cfg_write(5'h18, 32'hFFFF_FFFF);
        for (int i = 0; i < 5; i++) begin
            cfg_read(ofs[i], v);
            chk(v == words[i], "R2 readback", v, words[i]);
        end
        cfg_read(5'h0C, v);
        chk(v == 0, "R2 unmapped offset", v, 0);

        // R6 all-zero timing fields
        cfg_write(sp_ofs(0), pack(0, 0, 0, 0, 0, 0, 2));
        run_hit(0, 32'h0000_0100, 1'b0, 0, 1, 1, 1, "R6 read");
        run_hit(0, 32'h0000_0104, 1'b1, 32'hCAFE_0001, 1, 1, 1, "R6 write");

        // R10 maximum fields, reserved bits set
        cfg_write(sp_ofs(3), pack(15, 63, 3, 15, 63, 7, 2) | 32'h0000_C008);
        run_hit(3, 32'h0FFF_FFFC, 1'b0, 0, 15, 63, 7, "R10 max read");
        run_hit(3, 32'h0000_0000, 1'b1, 32'h0BAD_F00D, 15, 63, 3, "R10 max write");

        // R1 each space with distinct timing, offsets per R2
        for (int sp = 0; sp < 4; sp++)
            cfg_write(sp_ofs(sp), pack(sp + 1, sp + 2, sp, sp + 3, sp + 4, sp + 1, 2));
        for (int sp = 0; sp < 4; sp++)
            run_hit(sp, 32'(sp) * 32'h40, 1'b0, 0, plen(sp + 3), plen(sp + 4), plen(sp + 1), "R3 space read");

        // R7 addresses outside the spaces
        run_miss(32'h7FFF_FFFC, 1'b0, "R7 below");
        run_miss(32'hC000_0000, 1'b1, "R7 above");
        run_miss(32'h0000_0040, 1'b0, "R7 low");

        // R8 non-asynchronous type
        cfg_write(sp_ofs(2), pack(3, 3, 3, 3, 3, 3, 3));
        run_miss(32'hA000_0010, 1'b0, "R8 typed read");
        run_miss(32'hA000_0020, 1'b1, "R8 typed write");

        // Random transfers: R3, R4, R5, R10
        for (int n = 0; n < 40; n++) begin
            int sp, ws, wst, wh, rs, rsv, rh;
            bit we;
            sp = int'($urandom % 4);
            ws = int'($urandom % 16); wst = int'($urandom % 64); wh = int'($urandom % 4);
            rs = int'($urandom % 16); rsv = int'($urandom % 64); rh = int'($urandom % 8);
            we = 1'($urandom % 2);
            cfg_write(sp_ofs(sp), pack(ws, wst, wh, rs, rsv, rh, 2));
            if (we)
                run_hit(sp, $urandom, 1'b1, $urandom, plen(ws), plen(wst), plen(wh), "R4 random write");
            else
                run_hit(sp, $urandom, 1'b0, 0, plen(rs), plen(rsv), plen(rh), "R3 random read");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule